// File: doc/BRIEF.md
# Bus Target Diagnostic Status and Retry-Discard Timer

This block holds the diagnostic status word of a bus target. The word is 32 bits wide and collects three kinds of state. Sticky error flags are raised by one-cycle event pulses from the target's decode logic and are cleared by software writing a one. A 15-bit programmable count sets the length of the retry-discard timeout. A read-only bit shows whether the bus supply is 3.3 V or 5 V, as seen on an external sense pin.

The block also contains the retry-discard timer. The target pulses `retry_start` when it answers a delayed transaction with a retry. The timer then counts bus clocks. If the initiator has not come back when the programmed number of clocks has passed, the timer raises `discard_pulse` for one cycle so that the pending transaction can be dropped. A `txn_done` pulse cancels the wait.

Register access uses a write strobe, four byte enables and a 32-bit data path. The read data is valid in the same cycle, with no wait states.

Top module: `tgt_diag_regs`

## Requirements
- R1: While reset is held, the count and all flags clear to 0 and `discard_pulse` is low. After reset, `reg_rdata` reads 0 except for bit 0.
- R2: Bits 30:16 hold the retry-discard count. A write with `reg_be[2]` set loads count bits 7:0 from `reg_wdata[23:16]`. A write with `reg_be[3]` set loads count bits 14:8 from `reg_wdata[30:24]`.
- R3: Bit 31 and bits 15:4 of `reg_rdata` always read 0, whatever value is written.
- R4: Bit 3 is set by an `evt_overlap` pulse and bit 2 by an `evt_ro_write` pulse. Each bit reads 1 in the cycle after the pulse and stays set until it is cleared.
- R5: A write with `reg_be[0]` set and a 1 in bit 3, 2 or 1 clears that flag. A 0 in the bit, or a write with `reg_be[0]` low, leaves the flag unchanged.
- R6: Bit 1 has no hardware event and always reads 0.
- R7: If a flag's event pulse and a write-one-to-clear of the same flag come in the same cycle, the flag reads 1 afterwards.
- R8: Bit 0 shows `volt_sense_in` as sampled at the previous clock edge (0 = 3.3 V, 1 = 5 V). Writes have no effect on it.
- R9: Let the count be N > 0. After a `retry_start` pulse, `discard_pulse` goes high exactly N clocks later, for one cycle only. The timer then stays idle.
- R10: A count of 0 gives a timeout of 32768 clocks.
- R11: A `txn_done` pulse while the timer runs cancels it, and no `discard_pulse` follows.
- R12: A `retry_start` pulse while the timer runs restarts the full timeout from the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Assembled status word |
| evt_overlap | input | 1 | Pulse: a memory access hit both the expansion ROM window and the memory window |
| evt_ro_write | input | 1 | Pulse: a write targeted a read-only region |
| volt_sense_in | input | 1 | Bus supply sense pin (1 = 5 V) |
| retry_start | input | 1 | Pulse: a retry was issued for a delayed transaction |
| txn_done | input | 1 | Pulse: the initiator completed the pending transaction |
| discard_pulse | output | 1 | One-cycle pulse when the retry-discard timer expires |

## Verification
The hardest case to reach is the 32768-clock timeout for a zero count. The bench writes 0 to both count lanes, pulses `retry_start`, and steps the clock for over 32 thousand cycles while comparing every cycle against its model. Two other races also need exact timing: a flag event arriving with its own clear, and a restart that lands in the middle of a running countdown. The bench drives both so that the two pulses fall on the same edge, and then measures the distance to the discard pulse.

// File: rtl/tgt_diag_pkg.sv
package tgt_diag_pkg;
  localparam int WORD_W   = 32;
  localparam int BE_W     = WORD_W / 8;
  localparam int VS_BIT   = 0;
  localparam int FLAG_LO  = 1;
  localparam int FLAG_N   = 3;
  localparam int CNT_LO   = 16;
  localparam int CNT_W    = 15;
  // Flag indices within the sticky bank (bit = FLAG_LO + index).
  localparam int F_BADBE   = 0;
  localparam int F_ROWRITE = 1;
  localparam int F_OVERLAP = 2;
endpackage

// File: rtl/tgt_flag_bank.sv
module tgt_flag_bank #(
  parameter int          N        = 3,
  parameter logic [N-1:0] SET_MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] flags_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic set_en;
    assign set_en = set_evt[i] & SET_MASK[i];
    always_ff @(posedge clk) begin
      if (rst)
        flags_q[i] <= 1'b0;
      else
        flags_q[i] <= set_en | (flags_q[i] & ~clr_req[i]);
    end
  end
endmodule

// File: rtl/tgt_discard_timer.sv
module tgt_discard_timer #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             done,
  input  logic [CNT_W-1:0] cnt_val,
  output logic             discard
);
  localparam int TMR_W = CNT_W + 1;
  localparam logic [TMR_W-1:0] LONGEST = TMR_W'(1) << CNT_W;

  logic [TMR_W-1:0] remain_q;
  logic [TMR_W-1:0] load_val;
  logic             active_q;

  assign load_val = (cnt_val == '0) ? LONGEST : {1'b0, cnt_val};

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
      active_q <= 1'b0;
      discard  <= 1'b0;
    end else begin
      discard <= 1'b0;
      if (start) begin
        active_q <= 1'b1;
        remain_q <= load_val;
      end else if (active_q) begin
        if (done) begin
          active_q <= 1'b0;
        end else if (remain_q == TMR_W'(1)) begin
          discard  <= 1'b1;
          active_q <= 1'b0;
        end else begin
          remain_q <= remain_q - TMR_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/tgt_diag_regs.sv
module tgt_diag_regs
  import tgt_diag_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [BE_W-1:0]   reg_be,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              evt_overlap,
  input  logic              evt_ro_write,
  input  logic              volt_sense_in,
  input  logic              retry_start,
  input  logic              txn_done,
  output logic              discard_pulse
);
  localparam int CNT_HI   = CNT_LO + CNT_W - 1;
  localparam int LO_LANE  = CNT_LO / 8;
  localparam int HI_LANE  = LO_LANE + 1;
  localparam int HI_BITS  = CNT_W - 8;

  logic [CNT_W-1:0]  cnt_q;
  logic [FLAG_N-1:0] flags_q;
  logic [FLAG_N-1:0] flag_set;
  logic [FLAG_N-1:0] flag_clr;
  logic              vs_q;
  logic              unused_wbits;

  assign unused_wbits = ^{reg_wdata[WORD_W-1], reg_wdata[CNT_LO-1:FLAG_LO+FLAG_N],
                          reg_wdata[VS_BIT], reg_be[1]};

  // Supply sense sampled every clock, reset or not.
  always_ff @(posedge clk) vs_q <= volt_sense_in;

  // Count field, one byte lane at a time.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (reg_we) begin
      if (reg_be[LO_LANE]) cnt_q[7:0]       <= reg_wdata[CNT_LO +: 8];
      if (reg_be[HI_LANE]) cnt_q[CNT_W-1:8] <= reg_wdata[CNT_LO+8 +: HI_BITS];
    end
  end

  always_comb begin
    flag_set            = '0;
    flag_set[F_OVERLAP] = evt_overlap;
    flag_set[F_ROWRITE] = evt_ro_write;
    flag_clr            = (reg_we && reg_be[0]) ? reg_wdata[FLAG_LO +: FLAG_N] : '0;
  end

  tgt_flag_bank #(
    .N        (FLAG_N),
    .SET_MASK (3'b110)
  ) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_evt (flag_set),
    .clr_req (flag_clr),
    .flags_q (flags_q)
  );

  tgt_discard_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (retry_start),
    .done    (txn_done),
    .cnt_val (cnt_q),
    .discard (discard_pulse)
  );

  always_comb begin
    reg_rdata                        = '0;
    reg_rdata[VS_BIT]                = vs_q;
    reg_rdata[FLAG_LO +: FLAG_N]     = flags_q;
    reg_rdata[CNT_HI:CNT_LO]         = cnt_q;
  end
endmodule

// File: rtl/tgt_diag_chk.sv
module tgt_diag_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_we,
  input logic [3:0]  reg_be,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        evt_overlap,
  input logic        evt_ro_write,
  input logic        volt_sense_in,
  input logic        retry_start,
  input logic        txn_done,
  input logic        discard_pulse
);
  // R4
  overlap_sets_chk: assert property (@(posedge clk) disable iff (rst)
    evt_overlap |=> reg_rdata[3]);
  // R4
  overlap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[3] && !(reg_we && reg_be[0] && reg_wdata[3])) |=> reg_rdata[3]);
  // R5
  overlap_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_be[0] && reg_wdata[3] && !evt_overlap) |=> !reg_rdata[3]);
  // R7
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_ro_write && reg_we && reg_be[0] && reg_wdata[2]) |=> reg_rdata[2]);
  // R8
  vsense_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (reg_rdata[0] == $past(volt_sense_in)));
  // R2
  cnt_low_write_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_be[2]) |=> (reg_rdata[23:16] == $past(reg_wdata[23:16])));
  // R9
  discard_single_chk: assert property (@(posedge clk) disable iff (rst)
    discard_pulse |=> !discard_pulse);
  // R11
  done_cancels_chk: assert property (@(posedge clk) disable iff (rst)
    (txn_done && !retry_start) |=> !discard_pulse);
endmodule

bind tgt_diag_regs tgt_diag_chk u_chk (.*);

// File: tb/sim_tgt_diag_regs.sv
`timescale 1ns/1ps
module sim_tgt_diag_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_be = 4'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        evt_overlap = 1'b0, evt_ro_write = 1'b0, volt_sense_in = 1'b0;
  logic        retry_start = 1'b0, txn_done = 1'b0;
  logic        discard_pulse;

  always #4 clk = ~clk;

  tgt_diag_regs u0 (.*);

  int total = 0, bad = 0;

  // behavioural reference state
  int m_cnt = 0, m_remain = 0;
  bit m_f3, m_f2, m_f1, m_vs, m_run, m_disc;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_word();
    return {1'b0, 15'(m_cnt), 12'h0, m_f3, m_f2, m_f1, m_vs};
  endfunction

  task automatic step();
    bit [2:0] clr;
    @(posedge clk);
    m_vs = volt_sense_in;
    if (rst) begin
      m_cnt = 0; m_f3 = 0; m_f2 = 0; m_f1 = 0; m_run = 0; m_disc = 0; m_remain = 0;
    end else begin
      m_disc = 0;
      if (retry_start) begin
        m_run = 1; m_remain = (m_cnt == 0) ? 32768 : m_cnt;
      end else if (m_run) begin
        if (txn_done) m_run = 0;
        else if (m_remain == 1) begin m_disc = 1; m_run = 0; end
        else m_remain--;
      end
      clr = (reg_we && reg_be[0]) ? reg_wdata[3:1] : 3'b0;
      m_f3 = evt_overlap | (m_f3 & !clr[2]);
      m_f2 = evt_ro_write | (m_f2 & !clr[1]);
      m_f1 = m_f1 & !clr[0];
      if (reg_we && reg_be[2]) m_cnt = (m_cnt & 32'h7F00) | int'(reg_wdata[23:16]);
      if (reg_we && reg_be[3]) m_cnt = (m_cnt & 32'h00FF) | (int'(reg_wdata[30:24]) << 8);
    end
    #1;
    if (!rst) begin
      chk("model word", reg_rdata, m_word());
      chk("model discard", 32'(discard_pulse), 32'(m_disc));
    end
  endtask

  task automatic wr(logic [3:0] be, logic [31:0] d);
    reg_we = 1; reg_be = be; reg_wdata = d;
    step();
    reg_we = 0; reg_be = 0; reg_wdata = 0;
  endtask

  // run idle cycles until a discard shows; returns its cycle index or 0
  task automatic wait_disc(int max, output int at);
    at = 0;
    for (int i = 1; i <= max; i++) begin
      step();
      if (discard_pulse && at == 0) at = i;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int at;
    repeat (3) step();
    rst = 0;
    step();
    // R1 R3: clean word after reset, sense pin low
    chk("R1 reset word", reg_rdata, 32'h0);
    chk("R1 discard idle", 32'(discard_pulse), 32'h0);

    volt_sense_in = 1; step();
    chk("R8 sense high", 32'(reg_rdata[0]), 32'h1);
    wr(4'hF, 32'hFFFF_FFFF);
    // R2 R3 R6: full count, reserved zero, bit1 stays low
    chk("R3 all-ones write", reg_rdata, 32'h7FFF_0001);
    chk("R6 bit1 low", 32'(reg_rdata[1]), 32'h0);
    wr(4'hF, 32'h0000_0000);
    chk("R8 write ignored", 32'(reg_rdata[0]), 32'h1);
    wr(4'h4, 32'h00AB_0000);
    chk("R2 low lane", reg_rdata, 32'h00AB_0001);
    wr(4'h8, 32'h92CD_0000);
    chk("R2 high lane", reg_rdata, 32'h12AB_0001);

    evt_overlap = 1; step(); evt_overlap = 0;
    evt_ro_write = 1; step(); evt_ro_write = 0;
    repeat (4) step();
    chk("R4 sticky flags", reg_rdata, 32'h12AB_000D);
    wr(4'h0, 32'h0000_000E);
    chk("R5 lane off", reg_rdata, 32'h12AB_000D);
    wr(4'h1, 32'h0000_0000);
    chk("R5 zero write", reg_rdata, 32'h12AB_000D);
    wr(4'h1, 32'h0000_0008);
    chk("R5 clear bit3", reg_rdata, 32'h12AB_0005);
    evt_ro_write = 1; wr(4'h1, 32'h0000_0004); evt_ro_write = 0;
    chk("R7 set wins", reg_rdata, 32'h12AB_0005);
    wr(4'h1, 32'h0000_0004);
    chk("R5 clear bit2", reg_rdata, 32'h12AB_0001);
    volt_sense_in = 0; step();
    chk("R8 sense low", reg_rdata, 32'h12AB_0000);

    wr(4'hC, 32'h0005_0000);
    retry_start = 1; step(); retry_start = 0;
    wait_disc(12, at);
    chk("R9 timeout 5", 32'(at), 32'd5);
    retry_start = 1; step(); retry_start = 0;
    repeat (2) step();
    txn_done = 1; step(); txn_done = 0;
    wait_disc(12, at);
    chk("R11 cancelled", 32'(at), 32'd0);
    retry_start = 1; step(); retry_start = 0;
    repeat (2) step();
    retry_start = 1; step(); retry_start = 0;
    wait_disc(12, at);
    chk("R12 restart", 32'(at), 32'd5);
    wr(4'hC, 32'h0001_0000);
    retry_start = 1; step(); retry_start = 0;
    wait_disc(4, at);
    chk("R9 timeout 1", 32'(at), 32'd1);

    wr(4'hC, 32'h0000_0000);
    retry_start = 1; step(); retry_start = 0;
    wait_disc(32775, at);
    chk("R10 zero count", 32'(at), 32'd32768);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule